// File: doc/BRIEF.md
# Block Transfer Sequencer for Multi-Register Load, Store, Push and Pop

This controller carries out the multi-register transfer operations of a compact 16-bit instruction set. The operation kind, an 8-bit register list, a base register number, an extra-register flag and the current value of the base register (the stack pointer for push and pop) arrive already decoded. On `start` the sequencer walks the list and makes one 32-bit memory access per selected register over a request/acknowledge port. It reads store data from the register file and writes load results back to it. At the end it writes the final address back to the base or stack register.

The operation kind is encoded as 0 = load-multiple (increment after), 1 = store-multiple (increment after), 2 = pop, 3 = push. The extra flag adds the link register to a push or the program counter to a pop. Register numbers on the register-file ports are 0–7 for list registers, 13 for the stack pointer, 14 for the link register and 15 for the program counter.

Top module: `blk_xfer_seq`

## Requirements
- R1: Bit i of `reg_list` selects register i (0–7), and each set bit causes exactly one word access. For kinds 0 and 1 the `with_extra` flag is ignored.
- R2: Load- and store-multiple start at `base_val`, visit selected registers in ascending order, and add 4 to the address after each access. Store data is the register's value, and each load writes the returned word into that register.
- R3: Store-multiple always writes the final incremented address to register `base_sel` after its last access.
- R4: Load-multiple writes the final address to register `base_sel` only when bit `base_sel` of the list is clear. Otherwise that register keeps the loaded word.
- R5: Pop starts at `base_val` and loads in ascending order. With `with_extra` it then loads register 15 from the next word with bit 0 forced to zero. Register 13 finally receives the address after the last access.
- R6: Push starts at `base_val` minus 4 and subtracts 4 after each store. With `with_extra` it first stores register 14, then stores the selected registers from 7 down to 0. Register 13 finally receives the lowest address stored to.
- R7: A start with an empty list and no effective extra register makes no memory access and no register write, and `done` pulses in the cycle after the start edge.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` pulses. `done` lasts one cycle. `start` has no effect while `busy` is high.
- R9: A memory request keeps its address, write flag and data steady until `mem_ack`, whatever the acknowledge latency. A register write never coincides with a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| kind | input | 2 | 0 load-multiple, 1 store-multiple, 2 pop, 3 push |
| reg_list | input | 8 | Register selection, bit i = register i |
| base_sel | input | 3 | Base register number for kinds 0 and 1 |
| with_extra | input | 1 | Add link register (push) or program counter (pop) |
| base_val | input | 32 | Current value of the base or stack register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
The bench builds the sequencer with its default parameters: 32-bit words, an 8-entry list, an address step of 4, and register numbers 13, 14 and 15 for stack pointer, link register and program counter. With these, every list pattern from empty to full, the base-in-list case and both extra-register variants can be reached. The bench's memory model has an acknowledge latency that each scenario sets from 0 to 3 cycles, so requests are held for different lengths of time. Its read data always has bit 0 set, which makes the program-counter clearing visible.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    XK_LOADM  = 2'd0,
    XK_STOREM = 2'd1,
    XK_POP    = 2'd2,
    XK_PUSH   = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PICK  = 3'd1,
    ST_LATCH = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WB    = 3'd4
  } xfer_state_e;

endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] lo_idx,
  output logic [IW-1:0] hi_idx,
  output logic          any
);

  logic [W-1:0] below;
  logic [W-1:0] above;
  logic [W-1:0] lo_hit;
  logic [W-1:0] hi_hit;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_chain
      if (g == 0) begin : g_lo_first
        assign below[g] = 1'b0;
      end else begin : g_lo_rest
        assign below[g] = below[g-1] | mask[g-1];
      end
      if (g == W - 1) begin : g_hi_first
        assign above[g] = 1'b0;
      end else begin : g_hi_rest
        assign above[g] = above[g+1] | mask[g+1];
      end
      assign lo_hit[g] = mask[g] & ~below[g];
      assign hi_hit[g] = mask[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int k = 0; k < W; k++) begin
      if (lo_hit[k]) lo_idx = lo_idx | IW'(k);
      if (hi_hit[k]) hi_idx = hi_idx | IW'(k);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/xfer_addr_step.sv
module xfer_addr_step #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic [W-1:0] addr,
  input  logic         down,
  output logic [W-1:0] next
);

  localparam logic [W-1:0] STEP_V = W'(STEP);

  assign next = down ? (addr - STEP_V) : (addr + STEP_V);

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int DATA_W = 32,
  parameter int LIST_W = 8,
  parameter int BASE_W = 3,
  parameter int IDX_W  = 4,
  parameter int STEP   = 4,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic [LIST_W-1:0] reg_list,
  input  logic [BASE_W-1:0] base_sel,
  input  logic              with_extra,
  input  logic [DATA_W-1:0] base_val,
  output logic              busy,
  output logic              done,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import blk_xfer_pkg::*;

  localparam int PICK_W = (LIST_W > 1) ? $clog2(LIST_W) : 1;
  localparam logic [IDX_W-1:0] SP_I = IDX_W'(SP_IDX);
  localparam logic [IDX_W-1:0] LR_I = IDX_W'(LR_IDX);
  localparam logic [IDX_W-1:0] PC_I = IDX_W'(PC_IDX);

  xfer_state_e       st_q;
  xfer_kind_e        kind_q;
  logic [LIST_W-1:0] mask_q;
  logic              extra_q;
  logic [BASE_W-1:0] base_q;
  logic              base_hit_q;
  logic [DATA_W-1:0] addr_q;
  logic [IDX_W-1:0]  cur_idx_q;
  logic              cur_special_q;

  logic              busy_q, done_q;
  logic              rf_rd_en_q, rf_wr_en_q;
  logic [IDX_W-1:0]  rf_rd_idx_q, rf_wr_idx_q;
  logic [DATA_W-1:0] rf_wr_data_q;
  logic              mem_req_q, mem_we_q;
  logic [DATA_W-1:0] mem_addr_q, mem_wdata_q;

  // incoming-operation decode
  xfer_kind_e        kind_in;
  logic              ext_ok;
  logic              base_hit_in;
  logic              no_work;
  logic [DATA_W-1:0] push_init;
  logic [DATA_W-1:0] start_addr;

  assign kind_in     = xfer_kind_e'(kind);
  assign ext_ok      = with_extra && (kind_in == XK_POP || kind_in == XK_PUSH);
  assign base_hit_in = |(reg_list & (LIST_W'(1) << base_sel));
  assign no_work     = (reg_list == '0) && !ext_ok;

  xfer_addr_step #(.W(DATA_W), .STEP(STEP)) u_init (
    .addr(base_val), .down(1'b1), .next(push_init)
  );
  assign start_addr = (kind_in == XK_PUSH) ? push_init : base_val;

  // running-operation datapath
  logic              descend, is_store;
  logic [PICK_W-1:0] lo_idx, hi_idx, pick_idx;
  logic              any_left;
  logic              choose_special;
  logic [IDX_W-1:0]  item_idx;
  logic [LIST_W-1:0] pick_bit;
  logic              more;
  logic [DATA_W-1:0] addr_nx, addr_back;
  logic              wb_en;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;

  assign descend  = (kind_q == XK_PUSH);
  assign is_store = (kind_q == XK_STOREM) || (kind_q == XK_PUSH);

  xfer_pick #(.W(LIST_W)) u_pick (
    .mask(mask_q), .lo_idx(lo_idx), .hi_idx(hi_idx), .any(any_left)
  );

  assign pick_idx       = descend ? hi_idx : lo_idx;
  assign pick_bit       = LIST_W'(1) << pick_idx;
  assign choose_special = extra_q && (descend || !any_left);
  assign item_idx       = choose_special ? (descend ? LR_I : PC_I) : IDX_W'(pick_idx);
  assign more           = cur_special_q ? any_left
                                        : ((|(mask_q & ~pick_bit)) || extra_q);

  xfer_addr_step #(.W(DATA_W), .STEP(STEP)) u_step (
    .addr(addr_q), .down(descend), .next(addr_nx)
  );
  xfer_addr_step #(.W(DATA_W), .STEP(STEP)) u_back (
    .addr(addr_q), .down(1'b0), .next(addr_back)
  );

  assign wb_en   = !((kind_q == XK_LOADM) && base_hit_q);
  assign wb_idx  = (kind_q == XK_POP || kind_q == XK_PUSH) ? SP_I : IDX_W'(base_q);
  assign wb_data = descend ? addr_back : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      kind_q        <= XK_LOADM;
      mask_q        <= '0;
      extra_q       <= 1'b0;
      base_q        <= '0;
      base_hit_q    <= 1'b0;
      addr_q        <= '0;
      cur_idx_q     <= '0;
      cur_special_q <= 1'b0;
      busy_q        <= 1'b0;
      done_q        <= 1'b0;
      rf_rd_en_q    <= 1'b0;
      rf_rd_idx_q   <= '0;
      rf_wr_en_q    <= 1'b0;
      rf_wr_idx_q   <= '0;
      rf_wr_data_q  <= '0;
      mem_req_q     <= 1'b0;
      mem_we_q      <= 1'b0;
      mem_addr_q    <= '0;
      mem_wdata_q   <= '0;
    end else begin
      done_q     <= 1'b0;
      rf_wr_en_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            kind_q     <= kind_in;
            mask_q     <= reg_list;
            extra_q    <= ext_ok;
            base_q     <= base_sel;
            base_hit_q <= base_hit_in;
            addr_q     <= start_addr;
            if (no_work) begin
              done_q <= 1'b1;
            end else begin
              busy_q <= 1'b1;
              st_q   <= ST_PICK;
            end
          end
        end
        ST_PICK: begin
          cur_idx_q     <= item_idx;
          cur_special_q <= choose_special;
          rf_rd_en_q    <= is_store;
          rf_rd_idx_q   <= item_idx;
          st_q          <= ST_LATCH;
        end
        ST_LATCH: begin
          rf_rd_en_q  <= 1'b0;
          mem_req_q   <= 1'b1;
          mem_we_q    <= is_store;
          mem_addr_q  <= addr_q;
          mem_wdata_q <= is_store ? rf_rd_data : '0;
          st_q        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_ack) begin
            mem_req_q <= 1'b0;
            addr_q    <= addr_nx;
            if (!is_store) begin
              rf_wr_en_q   <= 1'b1;
              rf_wr_idx_q  <= cur_idx_q;
              rf_wr_data_q <= cur_special_q ? {mem_rdata[DATA_W-1:1], 1'b0} : mem_rdata;
            end
            if (cur_special_q) extra_q <= 1'b0;
            else               mask_q  <= mask_q & ~pick_bit;
            st_q <= more ? ST_PICK : ST_WB;
          end
        end
        ST_WB: begin
          rf_wr_en_q   <= wb_en;
          rf_wr_idx_q  <= wb_idx;
          rf_wr_data_q <= wb_data;
          busy_q       <= 1'b0;
          done_q       <= 1'b1;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign rf_rd_en   = rf_rd_en_q;
  assign rf_rd_idx  = rf_rd_idx_q;
  assign rf_wr_en   = rf_wr_en_q;
  assign rf_wr_idx  = rf_wr_idx_q;
  assign rf_wr_data = rf_wr_data_q;
  assign mem_req    = mem_req_q;
  assign mem_we     = mem_we_q;
  assign mem_addr   = mem_addr_q;
  assign mem_wdata  = mem_wdata_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R9
  wr_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> !mem_req);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  pc_even_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_wr_en && rf_wr_idx == PC_I) |-> !rf_wr_data[0]);

endmodule

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  kind;
  logic [7:0]  reg_list;
  logic [2:0]  base_sel;
  logic        with_extra;
  logic [31:0] base_val;
  logic        busy, done;
  logic        rf_rd_en;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  blk_xfer_seq dut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .reg_list(reg_list),
    .base_sel(base_sel), .with_extra(with_extra), .base_val(base_val),
    .busy(busy), .done(done),
    .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;

  // register file contents, written only by the bench
  logic [31:0] rf [16];
  assign rf_rd_data = rf[rf_rd_idx];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // memory model: acknowledge after lat wait cycles, log every access
  int          lat = 0;
  int          wcnt = 0;
  int          acc_n = 0;
  logic [31:0] la_addr [512];
  logic        la_we   [512];
  logic [31:0] la_data [512];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      wcnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= pat(mem_addr);
        wcnt      <= 0;
        la_addr[acc_n % 512] <= mem_addr;
        la_we[acc_n % 512]   <= mem_we;
        la_data[acc_n % 512] <= mem_wdata;
        acc_n <= acc_n + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // register write log
  int          wn = 0;
  logic [3:0]  lw_idx [512];
  logic [31:0] lw_dat [512];
  always @(posedge clk) begin
    if (!rst && rf_wr_en) begin
      lw_idx[wn % 512] <= rf_wr_idx;
      lw_dat[wn % 512] <= rf_wr_data;
      wn <= wn + 1;
    end
  end

  int all_cyc = 0;
  always @(posedge clk) begin
    all_cyc <= all_cyc + 1;
    if (all_cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung act=%0d exp<=150000", all_cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // runs one operation and compares against expectations computed from the requirements
  task automatic run_xfer(input string tag, input logic [1:0] k, input logic [7:0] lst,
                          input logic [2:0] bs, input logic ex, input logic [31:0] bv,
                          input int lt, input bit poke);
    logic [31:0] ea [20];
    logic        ew [20];
    logic [31:0] ed [20];
    logic [3:0]  xi [20];
    logic [31:0] xd [20];
    int          ne = 0;
    int          nx = 0;
    logic [31:0] a;
    bit          eff_ex;
    bit          empty;
    int          a0, w0, cyc;

    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + i * 32'h0101_0111;
    eff_ex = ex && k[1];
    empty  = (lst == 8'h00) && !eff_ex;

    if (k == 2'd3) begin
      a = bv - 32'd4;
      if (eff_ex) begin
        ea[ne] = a; ew[ne] = 1'b1; ed[ne] = rf[14]; ne++; a = a - 32'd4;
      end
      for (int i = 7; i >= 0; i--) begin
        if (lst[i]) begin ea[ne] = a; ew[ne] = 1'b1; ed[ne] = rf[i]; ne++; a = a - 32'd4; end
      end
      if (!empty) begin xi[nx] = 4'd13; xd[nx] = a + 32'd4; nx++; end
    end else begin
      a = bv;
      for (int i = 0; i < 8; i++) begin
        if (lst[i]) begin
          ea[ne] = a; ew[ne] = (k == 2'd1);
          ed[ne] = (k == 2'd1) ? rf[i] : 32'h0; ne++;
          if (k != 2'd1) begin xi[nx] = 4'(i); xd[nx] = pat(a); nx++; end
          a = a + 32'd4;
        end
      end
      if (k == 2'd2 && eff_ex) begin
        ea[ne] = a; ew[ne] = 1'b0; ed[ne] = 32'h0; ne++;
        xi[nx] = 4'd15; xd[nx] = pat(a) & 32'hFFFF_FFFE; nx++;
        a = a + 32'd4;
      end
      if (!empty) begin
        if (k == 2'd2)            begin xi[nx] = 4'd13; xd[nx] = a; nx++; end
        else if (k == 2'd1)       begin xi[nx] = 4'(bs); xd[nx] = a; nx++; end
        else if (!lst[bs])        begin xi[nx] = 4'(bs); xd[nx] = a; nx++; end
      end
    end

    lat = lt;
    a0  = acc_n;
    w0  = wn;
    @(negedge clk);
    kind = k; reg_list = lst; base_sel = bs; with_extra = ex; base_val = bv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (empty) begin
      chk(tag, "done one cycle after start", {31'd0, done}, 32'd1);
      chk(tag, "busy stays low", {31'd0, busy}, 32'd0);
    end else begin
      chk(tag, "busy after start", {31'd0, busy}, 32'd1);
      chk(tag, "no early done", {31'd0, done}, 32'd0);
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      kind = 2'd1; reg_list = ~lst; base_val = 32'h0000_0F00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(tag, "completion seen", {31'd0, done}, 32'd1);
    chk(tag, "busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(tag, "done is one cycle", {31'd0, done}, 32'd0);
    repeat (2) @(negedge clk);

    chk(tag, "access count", 32'(acc_n - a0), 32'(ne));
    for (int j = 0; j < ne && j < (acc_n - a0); j++) begin
      chk(tag, $sformatf("access %0d addr", j), la_addr[(a0 + j) % 512], ea[j]);
      chk(tag, $sformatf("access %0d write", j), {31'd0, la_we[(a0 + j) % 512]}, {31'd0, ew[j]});
      if (ew[j]) chk(tag, $sformatf("access %0d data", j), la_data[(a0 + j) % 512], ed[j]);
    end
    chk(tag, "register write count", 32'(wn - w0), 32'(nx));
    for (int j = 0; j < nx && j < (wn - w0); j++) begin
      chk(tag, $sformatf("write %0d index", j), {28'd0, lw_idx[(w0 + j) % 512]}, {28'd0, xi[j]});
      chk(tag, $sformatf("write %0d data", j), lw_dat[(w0 + j) % 512], xd[j]);
    end
  endtask

  task automatic t_reset;
    chk("R8", "reset busy", {31'd0, busy}, 32'd0);
    chk("R8", "reset done", {31'd0, done}, 32'd0);
    chk("R9", "reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R9", "reset rf_wr_en", {31'd0, rf_wr_en}, 32'd0);
  endtask

  // R2 R3: store-multiple, sparse list, extra flag ignored (R1)
  task automatic t_store_multi;
    run_xfer("R3", 2'd1, 8'b1010_0101, 3'd2, 1'b0, 32'h0000_0100, 0, 1'b0);
    run_xfer("R1", 2'd1, 8'b0000_0010, 3'd5, 1'b1, 32'h0000_0200, 1, 1'b0);
  endtask

  // R2 R4: load-multiple with base outside and inside the list
  task automatic t_load_multi;
    run_xfer("R2", 2'd0, 8'b0001_0110, 3'd0, 1'b0, 32'h0000_0300, 1, 1'b0);
    run_xfer("R4", 2'd0, 8'b0000_0110, 3'd2, 1'b0, 32'h0000_0400, 0, 1'b0);
    run_xfer("R1", 2'd0, 8'b1000_0000, 3'd7, 1'b1, 32'h0000_0480, 2, 1'b0);
  endtask

  // R5: pop with and without the program counter
  task automatic t_pop;
    run_xfer("R5", 2'd2, 8'b1000_0011, 3'd0, 1'b0, 32'h0000_0500, 0, 1'b0);
    run_xfer("R5", 2'd2, 8'b0100_1000, 3'd0, 1'b1, 32'h0000_0600, 2, 1'b0);
    run_xfer("R5", 2'd2, 8'b0000_0000, 3'd0, 1'b1, 32'h0000_0640, 1, 1'b0);
  endtask

  // R6: push with and without the link register
  task automatic t_push;
    run_xfer("R6", 2'd3, 8'b0100_0001, 3'd0, 1'b0, 32'h0000_0800, 0, 1'b0);
    run_xfer("R6", 2'd3, 8'b0000_0000, 3'd0, 1'b1, 32'h0000_0840, 1, 1'b0);
  endtask

  // R7: empty operations
  task automatic t_empty;
    run_xfer("R7", 2'd1, 8'h00, 3'd3, 1'b0, 32'h0000_0900, 0, 1'b0);
    run_xfer("R7", 2'd2, 8'h00, 3'd0, 1'b0, 32'h0000_0940, 0, 1'b0);
    run_xfer("R7", 2'd0, 8'h00, 3'd1, 1'b1, 32'h0000_0980, 0, 1'b0);
  endtask

  // R8 R9: full push with link register, long latency, start poked mid-run
  task automatic t_busy_poke;
    run_xfer("R8", 2'd3, 8'hFF, 3'd0, 1'b1, 32'h0000_0C00, 3, 1'b1);
    run_xfer("R9", 2'd0, 8'hFF, 3'd4, 1'b0, 32'h0000_0D00, 3, 1'b0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; kind = 2'd0; reg_list = 8'h00; base_sel = 3'd0;
    with_extra = 1'b0; base_val = 32'h0;
    for (int i = 0; i < 16; i++) rf[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_store_multi;
    t_load_multi;
    t_pop;
    t_push;
    t_empty;
    t_busy_poke;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule